// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and presents them to a processor on two outputs: a fast output and a normal output. Each source has its own enable bit. The enable bits are changed only through a pair of write-one-to-set and write-one-to-clear registers. A software trigger register can also be ORed into any source. A route register decides, source by source, which output a source drives.

Normal-output sources can be attached to sixteen vector slots. Each slot watches one source and holds a handler address. The lowest-numbered slot has the highest priority. A read of the vector register returns the winning handler address, or a default address when no slot matches. That read also opens a service level, which hides the winning slot and every lower-priority source from the normal output. A write to the vector register closes the most recent level. Service levels nest, so a higher-priority slot can still break in. The register interface is a simple two-phase select/enable bus with 32-bit data. Identification words at the top of the page give software a cell ID.

Top module: `vect_irq_ctrl`

## Requirements
- R1: After reset the outputs `irq_o` and `fiq_o` are low. The enable, route, software-trigger, protection and test-mode registers read 0, and the vector register (0x30) reads 0, which is the reset default address.
- R2: A write to 0x10 sets the enable bits where the data holds ones, and a write to 0x14 clears them where the data holds ones. Zero data bits leave an enable unchanged. The enable bits read back at 0x10.
- R3: Bit n of the route register (0x0C) sends source n to `fiq_o` when it is 1 and to `irq_o` when it is 0. 0x00 reads the enabled sources routed to the normal output, 0x04 reads those routed to the fast output, and 0x08 reads the unmasked sources.
- R4: The software-trigger bits are set by writing ones to 0x18 and cleared by writing ones to 0x1C. They read back at 0x18, and each bit is ORed with its hardware source before the enable.
- R5: `irq_o` and `fiq_o` are registered. A source change seen at one clock edge shows on the outputs after that edge, and not before.
- R6: Slot k has its handler address at 0x100+4k and its control word at 0x200+4k. In the control word, bit 5 turns the slot on and bits 4:0 pick the watched source. The control word reads back. A read of 0x30 returns the address of the lowest-numbered slot that is on and whose source is active on the normal output. If no slot matches, it returns the default address held at 0x34.
- R7: A read of 0x30 that returns a slot address opens a service level for that slot. While the level is open, that slot, all higher-numbered slots and all sources with no slot are kept off `irq_o`. A lower-numbered slot still raises `irq_o` and wins the next read.
- R8: Any write to 0x30 closes the most recently opened service level. A write to 0x30 with no level open has no effect.
- R9: The words at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return bytes 0 to 3 of the cell ID in bits 7:0, with bits 31:8 zero. Bits 19:12 of the assembled ID are the vendor code (0x5A by default).
- R10: The protection bit (0x20, bit 0) and the test-mode bit (0x300, bit 0) are stored and read back. Writes to them change nothing else.
- R11: A slot watching a source that is routed to the fast output never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus select (setup and access phases) |
| bus_en | input | 1 | Bus enable (access phase) |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the register page |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the access phase |
| src_i | input | 32 | Level-sensitive interrupt sources |
| irq_o | output | 1 | Normal interrupt request (registered) |
| fiq_o | output | 1 | Fast interrupt request (registered) |

## Verification
The bench nests service levels in three ways: a higher-priority slot preempts an open level, a source with no slot stays hidden behind an open level, and an extra close is issued on an empty stack. A tracker that masked the wrong side of the open slot would either leave `irq_o` stuck low or let a lower-priority request through. A tracker that underflowed would cause a later read to skip its push. Other directed cases cover the following:
- zero data written to the set and clear registers, which would corrupt the enables if either register acted as a plain store;
- a vector read with no eligible slot, which must return the default address without opening a level;
- a slot that is switched off, and a slot whose source is routed to the fast output, both of which would return a wrong handler address if the match ignored the slot's on bit or the route register;
- the one-cycle output delay.

// File: rtl/virq_pkg.sv
package virq_pkg;
    localparam int NSRC   = 32;
    localparam int DW     = 32;
    localparam int AW     = 12;
    localparam int NSLOT  = 16;
    localparam int SRC_W  = $clog2(NSRC);
    localparam int SLOT_W = $clog2(NSLOT);

    // Register offsets decoded by software
    localparam logic [AW-1:0] OFF_IRQ_ST = 12'h000;
    localparam logic [AW-1:0] OFF_FIQ_ST = 12'h004;
    localparam logic [AW-1:0] OFF_RAW    = 12'h008;
    localparam logic [AW-1:0] OFF_ROUTE  = 12'h00C;
    localparam logic [AW-1:0] OFF_EN_SET = 12'h010;
    localparam logic [AW-1:0] OFF_EN_CLR = 12'h014;
    localparam logic [AW-1:0] OFF_SW_SET = 12'h018;
    localparam logic [AW-1:0] OFF_SW_CLR = 12'h01C;
    localparam logic [AW-1:0] OFF_PROT   = 12'h020;
    localparam logic [AW-1:0] OFF_VEC    = 12'h030;
    localparam logic [AW-1:0] OFF_DFLT   = 12'h034;
    localparam logic [AW-1:0] OFF_TEST   = 12'h300;
    localparam logic [3:0]    PG_VADDR   = 4'h1;
    localparam logic [3:0]    PG_VCTRL   = 4'h2;
    localparam logic [7:0]    PG_IDENT   = 8'hFE;

    // Slot control word: bit SRC_W turns the slot on, low bits pick the source
    typedef struct packed {
        logic             on;
        logic [SRC_W-1:0] src;
    } slot_cfg_t;

    typedef enum logic [1:0] {BUS_IDLE, BUS_RD, BUS_WR} bus_op_e;

    function automatic logic [SLOT_W-1:0] first_set(input logic [NSLOT-1:0] v);
        logic [SLOT_W-1:0] idx;
        idx = '0;
        for (int k = NSLOT - 1; k >= 0; k--)
            if (v[k]) idx = SLOT_W'(k);
        return idx;
    endfunction
endpackage

// File: rtl/virq_vec_arb.sv
module virq_vec_arb
    import virq_pkg::*;
(
    input  logic [NSRC-1:0]   irq_act,
    input  slot_cfg_t         cfg [NSLOT],
    input  logic [NSLOT-1:0]  allow,
    output logic [NSLOT-1:0]  grant,
    output logic              hit,
    output logic [SLOT_W-1:0] win
);
    logic [NSLOT-1:0] req;

    for (genvar k = 0; k < NSLOT; k++) begin : g_req
        assign req[k] = cfg[k].on & irq_act[cfg[k].src] & allow[k];
    end

    // Isolate the lowest-numbered requesting slot
    assign grant = req & (~req + {{(NSLOT-1){1'b0}}, 1'b1});
    assign hit   = |req;
    assign win   = first_set(req);
endmodule

// File: rtl/virq_svc_track.sv
module virq_svc_track
    import virq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [NSLOT-1:0] push_sel,
    input  logic             pop,
    output logic [NSLOT-1:0] insvc,
    output logic [NSLOT-1:0] allow
);
    logic [NSLOT-1:0] upto;

    // A push is always higher priority than every open level, so the
    // lowest set bit is the top of the nesting stack.
    always_ff @(posedge clk) begin
        if (rst)
            insvc <= '0;
        else if (push)
            insvc <= insvc | push_sel;
        else if (pop)
            insvc <= insvc & (insvc - {{(NSLOT-1){1'b0}}, 1'b1});
    end

    assign upto[0] = insvc[0];
    for (genvar k = 1; k < NSLOT; k++) begin : g_prefix
        assign upto[k] = upto[k-1] | insvc[k];
    end

    assign allow = ~upto;
endmodule

// File: rtl/vect_irq_ctrl.sv
module vect_irq_ctrl
    import virq_pkg::*;
#(
    parameter logic [31:0] CELL_ID = 32'h0035_A0C1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_en,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [NSRC-1:0] src_i,
    output logic          irq_o,
    output logic          fiq_o
);
    logic [NSRC-1:0]   en_q, route_q, soft_q;
    logic              prot_q, test_q;
    logic [DW-1:0]     dflt_q;
    logic [DW-1:0]     vaddr_q [NSLOT];
    slot_cfg_t         cfg_q   [NSLOT];

    logic [NSRC-1:0]   raw, act, irq_act, fiq_act;
    logic [NSLOT-1:0]  grant, insvc, allow;
    logic              hit, busy;
    logic [SLOT_W-1:0] win;
    bus_op_e           op;
    logic              slot_ok;
    logic [SLOT_W-1:0] slot_idx;
    logic              push, pop;

    assign op = (bus_sel && bus_en) ? (bus_wr ? BUS_WR : BUS_RD) : BUS_IDLE;
    assign slot_ok  = (bus_addr[7:SLOT_W+2] == '0) && (bus_addr[1:0] == 2'b00);
    assign slot_idx = bus_addr[SLOT_W+1:2];

    assign raw     = src_i | soft_q;
    assign act     = raw & en_q;
    assign irq_act = act & ~route_q;
    assign fiq_act = act & route_q;

    virq_vec_arb u_arb (
        .irq_act (irq_act),
        .cfg     (cfg_q),
        .allow   (allow),
        .grant   (grant),
        .hit     (hit),
        .win     (win)
    );

    assign push = (op == BUS_RD) && (bus_addr == OFF_VEC) && hit;
    assign pop  = (op == BUS_WR) && (bus_addr == OFF_VEC);

    virq_svc_track u_trk (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_sel (grant),
        .pop      (pop),
        .insvc    (insvc),
        .allow    (allow)
    );

    assign busy = |insvc;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            route_q <= '0;
            soft_q  <= '0;
            prot_q  <= 1'b0;
            test_q  <= 1'b0;
            dflt_q  <= '0;
            irq_o   <= 1'b0;
            fiq_o   <= 1'b0;
            for (int k = 0; k < NSLOT; k++) begin
                vaddr_q[k] <= '0;
                cfg_q[k]   <= '0;
            end
        end else begin
            irq_o <= busy ? hit : |irq_act;
            fiq_o <= |fiq_act;
            if (op == BUS_WR) begin
                case (bus_addr)
                    OFF_ROUTE:  route_q <= bus_wdata;
                    OFF_EN_SET: en_q    <= en_q | bus_wdata;
                    OFF_EN_CLR: en_q    <= en_q & ~bus_wdata;
                    OFF_SW_SET: soft_q  <= soft_q | bus_wdata;
                    OFF_SW_CLR: soft_q  <= soft_q & ~bus_wdata;
                    OFF_PROT:   prot_q  <= bus_wdata[0];
                    OFF_DFLT:   dflt_q  <= bus_wdata;
                    OFF_TEST:   test_q  <= bus_wdata[0];
                    default: begin
                        if (slot_ok && bus_addr[11:8] == PG_VADDR)
                            vaddr_q[slot_idx] <= bus_wdata;
                        if (slot_ok && bus_addr[11:8] == PG_VCTRL)
                            cfg_q[slot_idx] <= bus_wdata[SRC_W:0];
                    end
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_IRQ_ST: bus_rdata = irq_act;
            OFF_FIQ_ST: bus_rdata = fiq_act;
            OFF_RAW:    bus_rdata = raw;
            OFF_ROUTE:  bus_rdata = route_q;
            OFF_EN_SET: bus_rdata = en_q;
            OFF_SW_SET: bus_rdata = soft_q;
            OFF_PROT:   bus_rdata = {{(DW-1){1'b0}}, prot_q};
            OFF_VEC:    bus_rdata = hit ? vaddr_q[win] : dflt_q;
            OFF_DFLT:   bus_rdata = dflt_q;
            OFF_TEST:   bus_rdata = {{(DW-1){1'b0}}, test_q};
            default: begin
                if (slot_ok && bus_addr[11:8] == PG_VADDR)
                    bus_rdata = vaddr_q[slot_idx];
                else if (slot_ok && bus_addr[11:8] == PG_VCTRL)
                    bus_rdata = {{(DW-SRC_W-1){1'b0}}, cfg_q[slot_idx]};
                else if (bus_addr[11:4] == PG_IDENT && bus_addr[1:0] == 2'b00)
                    bus_rdata = {24'b0, CELL_ID[{bus_addr[3:2], 3'b000} +: 8]};
            end
        endcase
    end
endmodule

// File: rtl/virq_chk.sv
module virq_chk
    import virq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_en,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic             irq_o,
    input logic [NSRC-1:0]  en_q,
    input logic [NSLOT-1:0] insvc,
    input logic [NSLOT-1:0] grant
);
    logic wr_acc, rd_acc;
    assign wr_acc = bus_sel && bus_en && bus_wr;
    assign rd_acc = bus_sel && bus_en && !bus_wr;

    assert_clear_all_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && bus_addr == OFF_EN_CLR && bus_wdata == '1) |=> (en_q == '0));

    assert_zero_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && (bus_addr == OFF_EN_SET || bus_addr == OFF_EN_CLR) && bus_wdata == '0)
        |=> $stable(en_q));

    assert_single_winner_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_open_level_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && bus_addr == OFF_VEC && grant != '0)
        |=> ($countones(insvc) == $past($countones(insvc)) + 1));

    assert_close_level_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && bus_addr == OFF_VEC && insvc != '0)
        |=> ($countones(insvc) + 1 == $past($countones(insvc))));

    assert_close_empty_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_acc && bus_addr == OFF_VEC && insvc == '0) |=> (insvc == '0));

    assert_quiet_when_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |=> !irq_o);
endmodule

bind vect_irq_ctrl virq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .en_q      (en_q),
    .insvc     (insvc),
    .grant     (grant)
);

// File: tb/vect_irq_ctrl_test.sv
module vect_irq_ctrl_test;
    localparam logic [31:0] ID = 32'h0035_A0C1;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_sel, bus_en, bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [31:0] src_i;
    logic        irq_o, fiq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    vect_irq_ctrl #(.CELL_ID(ID)) uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_i(src_i), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_en = 1'b0; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_en = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic t_reset();
        check("R1 irq_o", {31'b0, irq_o}, 32'h0);
        check("R1 fiq_o", {31'b0, fiq_o}, 32'h0);
        rd_chk("R1 enable", 12'h010, 32'h0);
        rd_chk("R1 route", 12'h00C, 32'h0);
        rd_chk("R1 soft", 12'h018, 32'h0);
        rd_chk("R1 prot", 12'h020, 32'h0);
        rd_chk("R1 test", 12'h300, 32'h0);
        rd_chk("R1 vector", 12'h030, 32'h0);
    endtask

    task automatic t_enable();
        wr(12'h010, 32'h0000_00F0);
        rd_chk("R2 set", 12'h010, 32'h0000_00F0);
        wr(12'h010, 32'h0);
        rd_chk("R2 set zero", 12'h010, 32'h0000_00F0);
        wr(12'h014, 32'h0000_0030);
        rd_chk("R2 clear", 12'h010, 32'h0000_00C0);
        wr(12'h014, 32'h0);
        rd_chk("R2 clear zero", 12'h010, 32'h0000_00C0);
        wr(12'h014, 32'hFFFF_FFFF);
        rd_chk("R2 clear all", 12'h010, 32'h0);
    endtask

    task automatic t_route();
        wr(12'h010, 32'h0000_00FF);
        wr(12'h00C, 32'h0000_0002);
        settle();
        src_i = 32'h0000_0001;
        #1 check("R5 irq_o before edge", {31'b0, irq_o}, 32'h0);
        settle();
        check("R5 irq_o after edge", {31'b0, irq_o}, 32'h1);
        src_i = 32'h0000_0003;
        settle();
        check("R3 irq_o", {31'b0, irq_o}, 32'h1);
        check("R3 fiq_o", {31'b0, fiq_o}, 32'h1);
        rd_chk("R3 irq status", 12'h000, 32'h0000_0001);
        rd_chk("R3 fiq status", 12'h004, 32'h0000_0002);
        rd_chk("R3 raw", 12'h008, 32'h0000_0003);
        wr(12'h014, 32'h0000_0001);
        settle();
        check("R3 masked irq_o", {31'b0, irq_o}, 32'h0);
        rd_chk("R3 raw unmasked", 12'h008, 32'h0000_0003);
        src_i = 32'h0;
        wr(12'h014, 32'hFFFF_FFFF);
        wr(12'h00C, 32'h0);
        settle();
        check("R3 fiq_o off", {31'b0, fiq_o}, 32'h0);
    endtask

    task automatic t_soft();
        wr(12'h010, 32'h0000_0010);
        wr(12'h018, 32'h0000_0010);
        settle();
        check("R4 soft irq_o", {31'b0, irq_o}, 32'h1);
        rd_chk("R4 soft readback", 12'h018, 32'h0000_0010);
        rd_chk("R4 raw with soft", 12'h008, 32'h0000_0010);
        wr(12'h01C, 32'h0000_0010);
        settle();
        check("R4 soft cleared", {31'b0, irq_o}, 32'h0);
        rd_chk("R4 soft zero", 12'h018, 32'h0);
        wr(12'h014, 32'hFFFF_FFFF);
    endtask

    task automatic t_vector();
        wr(12'h200, 32'h0000_0025); wr(12'h100, 32'h0000_A000);
        wr(12'h204, 32'h0000_0005); wr(12'h104, 32'h0000_A100);
        wr(12'h20C, 32'h0000_0027); wr(12'h10C, 32'h0000_A300);
        wr(12'h21C, 32'h0000_0029); wr(12'h11C, 32'h0000_A700);
        wr(12'h034, 32'h0000_D000);
        wr(12'h010, 32'h0000_12A0);
        rd_chk("R6 control readback", 12'h20C, 32'h0000_0027);
        src_i = 32'h0000_0200;
        settle();
        check("R7 idle irq_o", {31'b0, irq_o}, 32'h1);
        rd_chk("R6 slot7 address", 12'h030, 32'h0000_A700);
        settle();
        check("R7 open level hides slot7", {31'b0, irq_o}, 32'h0);
        src_i = 32'h0000_1200;
        settle();
        check("R7 unslotted source hidden", {31'b0, irq_o}, 32'h0);
        rd_chk("R6 default address", 12'h030, 32'h0000_D000);
        src_i = 32'h0000_1280;
        settle();
        check("R7 higher slot preempts", {31'b0, irq_o}, 32'h1);
        rd_chk("R7 nested slot3", 12'h030, 32'h0000_A300);
        settle();
        check("R7 nested level masks", {31'b0, irq_o}, 32'h0);
        wr(12'h030, 32'h0);
        settle();
        check("R8 close reopens slot3", {31'b0, irq_o}, 32'h1);
        rd_chk("R8 slot3 again", 12'h030, 32'h0000_A300);
        wr(12'h030, 32'h0);
        wr(12'h030, 32'h0);
        wr(12'h030, 32'h0);
        rd_chk("R8 after empty close", 12'h030, 32'h0000_A300);
        settle();
        check("R8 level opened after empty close", {31'b0, irq_o}, 32'h0);
        wr(12'h030, 32'h0);
        src_i = 32'h0000_0020;
        settle();
        rd_chk("R6 slot0 address", 12'h030, 32'h0000_A000);
        wr(12'h030, 32'h0);
        wr(12'h200, 32'h0000_0005);
        rd_chk("R6 slot off uses default", 12'h030, 32'h0000_D000);
        settle();
        check("R6 no level on default", {31'b0, irq_o}, 32'h1);
        wr(12'h200, 32'h0000_0025);
        wr(12'h00C, 32'h0000_0020);
        settle();
        check("R11 irq_o off", {31'b0, irq_o}, 32'h0);
        check("R11 fiq_o on", {31'b0, fiq_o}, 32'h1);
        rd_chk("R11 fast source no match", 12'h030, 32'h0000_D000);
        src_i = 32'h0;
        wr(12'h00C, 32'h0);
        wr(12'h014, 32'hFFFF_FFFF);
    endtask

    task automatic t_ident();
        logic [31:0] asm_id;
        asm_id = '0;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] d;
            rd(12'hFE0 + 12'(4 * i), d);
            check("R9 id word", d, {24'b0, ID[8*i +: 8]});
            asm_id[8*i +: 8] = d[7:0];
        end
        check("R9 vendor", {24'b0, asm_id[19:12]}, 32'h0000_005A);
    endtask

    task automatic t_misc();
        wr(12'h020, 32'hFFFF_FFFF);
        rd_chk("R10 prot", 12'h020, 32'h1);
        wr(12'h300, 32'h1);
        rd_chk("R10 test", 12'h300, 32'h1);
        rd_chk("R10 enables untouched", 12'h010, 32'h0);
        wr(12'h300, 32'h0);
        rd_chk("R10 test cleared", 12'h300, 32'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0; src_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        settle();
        t_reset();
        t_enable();
        t_route();
        t_soft();
        t_vector();
        t_ident();
        t_misc();
        finish_run();
    end
endmodule